// File: doc/BRIEF.md
# Two-Stage Bus Watchdog

This block is a watchdog timer on an APB slave port with a 32-bit data bus and a 12-bit byte offset. It has a down-counter that steps once for each cycle of the bus clock in which the `tick_en` input is high. When the count first runs out, the block raises an interrupt and restarts the count from the reload value. If software has not cleared the interrupt before the count runs out a second time, the block raises a reset request and the counter stops.

Software restarts the count by writing the reload register or the interrupt-clear register. A key-protected lock can block every write except a write to the lock register itself. A test mode lets software drive both outputs directly. A fixed set of identification bytes can be read. The parameter `ALT_VARIANT` selects a second variant. In that variant the test registers are removed, a stall register reads as zero, and the control register stops accepting writes once the interrupt enable is set.

Top module: `apb_wdog`

## Requirements
- R1: After reset, control, raw flag, reset status, lock, test mode and test outputs are 0. Reload (0x000) and count (0x004) read 0xFFFFFFFF, and the counter is running.
- R2: Control (0x008) keeps only bit 0 (interrupt enable) and bit 1 (reset enable). All other bits read back as 0.
- R3: A write to reload (0x000) sets both the reload value and the count, and starts the counter. The count drops by one on each cycle with `tick_en` high. A bus write in the same cycle as a tick takes priority over the tick.
- R4: When a tick takes the count from 1 with the raw flag (0x010 bit 0) clear, the flag sets and the count reloads in that same cycle.
- R5: When a tick takes the count from 1 with the raw flag already set, the reset status sets, the count becomes 0, and the counter stays stopped until the reload register is written.
- R6: Any write to interrupt-clear (0x00C) clears the raw flag and reloads the count.
- R7: `irq_o` = raw flag AND control bit 0. `rst_req_o` = reset status AND control bit 1. Masked status (0x014) reads raw flag AND control bit 0.
- R8: Writing 0x1ACCE551 to lock (0xC00) unlocks the block, and any other value locks it. Lock reads 1 when locked and 0 when unlocked. While locked, writes to all other offsets are ignored.
- R9: With test-mode (0xF00) bit 0 set, `irq_o` follows bit 1 and `rst_req_o` follows bit 0 of the test-output register (0xF04).
- R10: Reads of write-only offsets (0x00C, 0xF04) and unmapped offsets return 0. Writes to read-only offsets (0x004, 0x010, 0x014, identification) and unmapped offsets have no effect.
- R11: Identification words 0xFD0..0xFFC return one byte each in bits 7:0. Default variant, in address order: 04,00,00,00,24,B8,1B,00,0D,F0,05,B1. Alternate variant: 00,00,00,00,05,18,18,01,0D,F0,05,B1.
- R12: In the alternate variant, 0xF00 and 0xF04 are unmapped and 0x418 reads 0 and ignores writes. Once control bit 0 is set, control writes are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tick_en | input | 1 | Counter step enable |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | 1 | Reset request output |

## Verification
The bench targets these corner cases:

- **Expiry boundaries.** It counts ticks exactly to each expiry. A design that expires at zero rather than on the step from one would show the flag a tick late. A design that does not stop would leave a nonzero count after further ticks.
- **Write paths that must be ignored.** It checks lock blocking, the write-once control of the alternate variant, and writes to read-only offsets. A leaky decode would show up as changed readback or changed outputs.
- **Address decode.** It sweeps every word offset against a computed map in a known state. Aliasing or wrong identification bytes would show up there.
- **Test override.** It toggles the override in both directions. A design that swaps the two test bits would drive the wrong output.

// File: rtl/apb_wdog_pkg.sv
package apb_wdog_pkg;
   localparam int unsigned OFS_W = 12;
   localparam logic [OFS_W-1:0] OFS_RELOAD = 12'h000;
   localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
   localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
   localparam logic [OFS_W-1:0] OFS_ICLR   = 12'h00C;
   localparam logic [OFS_W-1:0] OFS_RAW    = 12'h010;
   localparam logic [OFS_W-1:0] OFS_MASKED = 12'h014;
   localparam logic [OFS_W-1:0] OFS_STALL  = 12'h418;
   localparam logic [OFS_W-1:0] OFS_LOCK   = 12'hC00;
   localparam logic [OFS_W-1:0] OFS_TMODE  = 12'hF00;
   localparam logic [OFS_W-1:0] OFS_TOUT   = 12'hF04;
   localparam logic [OFS_W-1:0] OFS_ID_LO  = 12'hFD0;
   localparam logic [OFS_W-1:0] OFS_ID_HI  = 12'hFFC;
   localparam logic [31:0]      UNLOCK_KEY = 32'h1ACCE551;

   // identification byte by word index counted from OFS_ID_LO
   function automatic logic [7:0] id_byte(input logic alt, input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = alt ? 8'h00 : 8'h04;
         4'd4:    b = alt ? 8'h05 : 8'h24;
         4'd5:    b = alt ? 8'h18 : 8'hB8;
         4'd6:    b = alt ? 8'h18 : 8'h1B;
         4'd7:    b = alt ? 8'h01 : 8'h00;
         4'd8:    b = 8'h0D;
         4'd9:    b = 8'hF0;
         4'd10:   b = 8'h05;
         4'd11:   b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr_we,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output logic             raw,
   output logic             rstat
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic running;
   logic expire;

   assign expire = tick && running && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '1;
         reload  <= '1;
         running <= 1'b1;
         raw     <= 1'b0;
         rstat   <= 1'b0;
      end else if (load_we) begin
         reload  <= load_val;
         cnt     <= load_val;
         running <= 1'b1;
      end else if (clr_we) begin
         raw <= 1'b0;
         cnt <= reload;
      end else if (expire) begin
         if (!raw) begin
            raw <= 1'b1;
            cnt <= reload;
         end else begin
            rstat   <= 1'b1;
            running <= 1'b0;
            cnt     <= '0;
         end
      end else if (tick && running) begin
         cnt <= cnt - CNT_ONE;
      end
   end

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && running && !load_we && !clr_we && cnt > CNT_ONE) |=> (cnt == $past(cnt) - CNT_ONE));
   // R3
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> (running && cnt == $past(load_val)));
   // R4
   first_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !raw && !load_we && !clr_we) |=> (raw && cnt == reload));
   // R5
   second_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && raw && !load_we && !clr_we) |=> (rstat && !running && cnt == '0));
   // R5
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !load_we && !clr_we) |=> ($stable(cnt) && !running));
   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !load_we) |=> !raw);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import apb_wdog_pkg::*;
#(
   parameter bit ALT_VARIANT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [OFS_W-1:0] addr,
   input  logic [31:0]      wdata,
   output logic             load_we,
   output logic             clr_we,
   output logic [1:0]       ctrl,
   output logic             locked,
   output logic             tmode,
   output logic [1:0]       tout
);
   logic we_ok;
   logic ctrl_open;

   assign we_ok   = we && (!locked || addr == OFS_LOCK);
   assign load_we = we_ok && (addr == OFS_RELOAD);
   assign clr_we  = we_ok && (addr == OFS_ICLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (we && addr == OFS_LOCK)
         locked <= (wdata != UNLOCK_KEY);
   end

   generate
      if (ALT_VARIANT) begin : g_ctrl_once
         assign ctrl_open = !ctrl[0];
      end else begin : g_ctrl_free
         assign ctrl_open = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= 2'b00;
      else if (we_ok && addr == OFS_CTRL && ctrl_open)
         ctrl <= wdata[1:0];
   end

   generate
      if (ALT_VARIANT) begin : g_no_test
         assign tmode = 1'b0;
         assign tout  = 2'b00;
         // R12
         ctrl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl[0] |=> (ctrl == $past(ctrl)));
      end else begin : g_test
         logic       tmode_q;
         logic [1:0] tout_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tmode_q <= 1'b0;
               tout_q  <= 2'b00;
            end else begin
               if (we_ok && addr == OFS_TMODE) tmode_q <= wdata[0];
               if (we_ok && addr == OFS_TOUT)  tout_q  <= wdata[1:0];
            end
         end
         assign tmode = tmode_q;
         assign tout  = tout_q;
      end
   endgenerate

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && locked && addr != OFS_LOCK) |=> ($stable(ctrl) && $stable(tmode) && $stable(tout)));
   // R8
   lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == OFS_LOCK) |=> (locked == ($past(wdata) != UNLOCK_KEY)));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
   import apb_wdog_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter bit          ALT_VARIANT = 1'b0
) (
   input  logic [OFS_W-1:0] addr,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload,
   input  logic [1:0]       ctrl,
   input  logic             raw,
   input  logic             locked,
   input  logic             tmode,
   output logic [31:0]      rdata
);
   logic [OFS_W-1:0] id_off;
   logic             id_hit;
   logic             tmode_map;

   assign id_off = addr - OFS_ID_LO;
   assign id_hit = (addr >= OFS_ID_LO) && (addr <= OFS_ID_HI) && (addr[1:0] == 2'b00);

   generate
      if (ALT_VARIANT) begin : g_alt_map
         assign tmode_map = 1'b0;
      end else begin : g_def_map
         assign tmode_map = 1'b1;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (id_hit) begin
         rdata = {24'h0, id_byte(ALT_VARIANT, id_off[5:2])};
      end else begin
         case (addr)
            OFS_RELOAD: rdata = 32'(reload);
            OFS_COUNT:  rdata = 32'(cnt);
            OFS_CTRL:   rdata = {30'h0, ctrl};
            OFS_RAW:    rdata = {31'h0, raw};
            OFS_MASKED: rdata = {31'h0, raw & ctrl[0]};
            OFS_LOCK:   rdata = {31'h0, locked};
            OFS_TMODE:  rdata = {31'h0, tmode & tmode_map};
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
   import apb_wdog_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter bit          ALT_VARIANT = 1'b0
) (
   input  logic             pclk,
   input  logic             presetn,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [OFS_W-1:0] paddr,
   input  logic [31:0]      pwdata,
   output logic [31:0]      prdata,
   output logic             pready,
   output logic             pslverr,
   input  logic             tick_en,
   output logic             irq_o,
   output logic             rst_req_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("apb_wdog: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             bus_we;
   logic             load_we;
   logic             clr_we;
   logic [1:0]       ctrl;
   logic             locked;
   logic             tmode;
   logic [1:0]       tout;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;
   logic             raw;
   logic             rstat;

   assign bus_we  = psel && penable && pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   wdog_regs #(.ALT_VARIANT(ALT_VARIANT)) u_regs (
      .clk(pclk), .rst_n(presetn), .we(bus_we), .addr(paddr), .wdata(pwdata),
      .load_we(load_we), .clr_we(clr_we), .ctrl(ctrl), .locked(locked),
      .tmode(tmode), .tout(tout)
   );

   wdog_count #(.CNT_W(CNT_W)) u_count (
      .clk(pclk), .rst_n(presetn), .tick(tick_en), .load_we(load_we),
      .load_val(pwdata[CNT_W-1:0]), .clr_we(clr_we), .cnt(cnt),
      .reload(reload), .raw(raw), .rstat(rstat)
   );

   wdog_rdmux #(.CNT_W(CNT_W), .ALT_VARIANT(ALT_VARIANT)) u_rdmux (
      .addr(paddr), .cnt(cnt), .reload(reload), .ctrl(ctrl), .raw(raw),
      .locked(locked), .tmode(tmode), .rdata(prdata)
   );

   always_comb begin
      if (tmode) begin
         irq_o     = tout[1];
         rst_req_o = tout[0];
      end else begin
         irq_o     = raw & ctrl[0];
         rst_req_o = rstat & ctrl[1];
      end
   end

   // R7
   irq_mask_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (!tmode && !ctrl[0]) |-> !irq_o);
   // R9
   test_ovr_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (bus_we && !locked && !ALT_VARIANT && paddr == OFS_TOUT && tmode && !(pwdata[1] ^ pwdata[0]))
      |=> (irq_o == rst_req_o));
endmodule

// File: tb/apb_wdog_test.sv
`timescale 1ns/1ps
module apb_wdog_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel_d = 1'b0, psel_a = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic        tick_en = 1'b0;
   logic [31:0] rdata_d, rdata_a;
   logic        rdy_d, rdy_a, err_d, err_a;
   logic        irq_d, rst_d, irq_a, rst_a;
   int          n_chk = 0, n_bad = 0;

   localparam logic [31:0] KEY = 32'h1ACCE551;

   always #2.5 clk = ~clk;

   apb_wdog #(.CNT_W(32), .ALT_VARIANT(1'b0)) uut (
      .pclk(clk), .presetn(rst_n), .psel(psel_d), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(rdata_d), .pready(rdy_d), .pslverr(err_d),
      .tick_en(tick_en), .irq_o(irq_d), .rst_req_o(rst_d));

   apb_wdog #(.CNT_W(32), .ALT_VARIANT(1'b1)) uut_alt (
      .pclk(clk), .presetn(rst_n), .psel(psel_a), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(rdata_a), .pready(rdy_a), .pslverr(err_a),
      .tick_en(tick_en), .irq_o(irq_a), .rst_req_o(rst_a));

   function automatic logic [7:0] exp_id(input bit alt, input int idx);
      logic [7:0] d [12] = '{8'h04,8'h00,8'h00,8'h00,8'h24,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
      logic [7:0] a [12] = '{8'h00,8'h00,8'h00,8'h00,8'h05,8'h18,8'h18,8'h01,8'h0D,8'hF0,8'h05,8'hB1};
      return alt ? a[idx] : d[idx];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input bit alt, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      if (alt) psel_a = 1'b1; else psel_d = 1'b1;
      pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel_d = 1'b0; psel_a = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input bit alt, input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      if (alt) psel_a = 1'b1; else psel_d = 1'b1;
      pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      d = alt ? rdata_a : rdata_d;
      @(negedge clk);
      psel_d = 1'b0; psel_a = 1'b0; penable = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic rchk(input string req, input bit alt, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(alt, a, v);
      chk(req, v, exp);
   endtask

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rchk("R1 reload", 0, 12'h000, 32'hFFFF_FFFF);
      rchk("R1 count", 0, 12'h004, 32'hFFFF_FFFF);
      rchk("R1 ctrl", 0, 12'h008, 0);
      rchk("R1 raw", 0, 12'h010, 0);
      rchk("R1 lock", 0, 12'hC00, 0);
      rchk("R1 tmode", 0, 12'hF00, 0);
      chk("R1 outputs", {30'h0, irq_d, rst_d}, 0);
      chk("R1 bus ready/err", {30'h0, rdy_d, err_d}, 32'h2);
      // R2 control masking
      wr(0, 12'h008, 32'hFFFF_FFFC);
      rchk("R2 ctrl upper bits", 0, 12'h008, 0);
      wr(0, 12'h008, 32'h0000_000F);
      rchk("R2 ctrl kept bits", 0, 12'h008, 3);
      // R3 load and count
      wr(0, 12'h000, 5);
      rchk("R3 count after load", 0, 12'h004, 5);
      ticks(2);
      rchk("R3 count after 2 ticks", 0, 12'h004, 3);
      // R4 first expiry
      ticks(3);
      rchk("R4 raw set", 0, 12'h010, 1);
      rchk("R4 reloaded", 0, 12'h004, 5);
      chk("R7 irq", {31'h0, irq_d}, 1);
      rchk("R7 masked", 0, 12'h014, 1);
      wr(0, 12'h008, 2);
      chk("R7 irq masked off", {31'h0, irq_d}, 0);
      rchk("R7 masked off", 0, 12'h014, 0);
      wr(0, 12'h008, 3);
      // R6 interrupt clear
      ticks(2);
      wr(0, 12'h00C, 32'hDEAD_BEEF);
      rchk("R6 raw cleared", 0, 12'h010, 0);
      rchk("R6 count reloaded", 0, 12'h004, 5);
      chk("R6 irq low", {31'h0, irq_d}, 0);
      // R5 second expiry
      ticks(5);
      rchk("R4 raw again", 0, 12'h010, 1);
      ticks(4);
      rchk("R5 count at 1", 0, 12'h004, 1);
      chk("R5 no reset yet", {31'h0, rst_d}, 0);
      ticks(1);
      chk("R5 reset request", {31'h0, rst_d}, 1);
      rchk("R5 count zero", 0, 12'h004, 0);
      ticks(3);
      rchk("R5 counter stopped", 0, 12'h004, 0);
      // R10 read-only writes ignored
      wr(0, 12'h004, 32'h123);
      rchk("R10 count write ignored", 0, 12'h004, 0);
      wr(0, 12'h010, 0);
      rchk("R10 raw write ignored", 0, 12'h010, 1);
      wr(0, 12'h014, 0);
      wr(0, 12'hFE0, 32'hFF);
      wr(0, 12'h200, 32'hFFFF_FFFF);
      chk("R10 outputs after ignored writes", {30'h0, irq_d, rst_d}, 3);
      // R10 R11 full offset sweep in known state
      for (int w = 0; w < 1024; w++) begin
         logic [11:0] a;
         logic [31:0] e;
         a = 12'(w * 4);
         case (a)
            12'h000: e = 5;
            12'h008: e = 3;
            12'h010: e = 1;
            12'h014: e = 1;
            default: e = (a >= 12'hFD0) ? {24'h0, exp_id(0, (w * 4 - 'hFD0) / 4)} : 0;
         endcase
         rchk("R10/R11 sweep", 0, a, e);
      end
      // R9 test override
      wr(0, 12'hF00, 1);
      wr(0, 12'hF04, 2);
      chk("R9 tout=2", {30'h0, irq_d, rst_d}, 2);
      wr(0, 12'hF04, 1);
      chk("R9 tout=1", {30'h0, irq_d, rst_d}, 1);
      wr(0, 12'hF04, 0);
      chk("R9 tout=0", {30'h0, irq_d, rst_d}, 0);
      rchk("R10 tout reads zero", 0, 12'hF04, 0);
      wr(0, 12'hF00, 0);
      chk("R9 override released", {30'h0, irq_d, rst_d}, 3);
      // R8 lock
      wr(0, 12'hC00, 0);
      rchk("R8 locked", 0, 12'hC00, 1);
      wr(0, 12'h008, 0);
      rchk("R8 ctrl write blocked", 0, 12'h008, 3);
      wr(0, 12'h000, 9);
      rchk("R8 reload write blocked", 0, 12'h000, 5);
      wr(0, 12'hF00, 1);
      wr(0, 12'h00C, 0);
      chk("R8 outputs unchanged", {30'h0, irq_d, rst_d}, 3);
      wr(0, 12'hC00, KEY + 1);
      rchk("R8 near-key locks", 0, 12'hC00, 1);
      wr(0, 12'hC00, KEY);
      rchk("R8 unlocked", 0, 12'hC00, 0);
      wr(0, 12'h008, 0);
      rchk("R8 ctrl writable", 0, 12'h008, 0);
      // R3 reload restarts a stopped counter
      wr(0, 12'h000, 3);
      ticks(1);
      rchk("R3 restart after stop", 0, 12'h004, 2);
      // R12 alternate variant
      rchk("R12 tmode unmapped", 1, 12'hF00, 0);
      wr(1, 12'hF00, 1);
      wr(1, 12'hF04, 3);
      chk("R12 no override", {30'h0, irq_a, rst_a}, 0);
      wr(1, 12'h418, 32'hFFFF_FFFF);
      rchk("R12 stall reads zero", 1, 12'h418, 0);
      wr(1, 12'h008, 2);
      rchk("R12 ctrl open", 1, 12'h008, 2);
      wr(1, 12'h008, 1);
      rchk("R12 ctrl set", 1, 12'h008, 1);
      wr(1, 12'h008, 2);
      rchk("R12 ctrl frozen", 1, 12'h008, 1);
      for (int i = 0; i < 12; i++)
         rchk("R11 alt id", 1, 12'(12'hFD0 + i * 4), {24'h0, exp_id(1, i)});
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule